// File: doc/BRIEF.md
# Ones-Fill Shift Execution Slice

This block is a purely combinational decode-and-execute slice for a 64-bit integer core. It looks at a 32-bit instruction word and recognises eight bit-manipulation shifts: left and right, each in register, immediate, 32-bit word register and 32-bit word immediate form. Unlike an ordinary logical shift, the positions that the shift vacates are filled with ones. The result is obtained by inverting the operand, shifting it with zero fill, and inverting again.

The issue stage hands the slice the instruction, both source operands and an enable for the bit-manipulation extension. In the same cycle the slice returns a 64-bit result, a flag that says it claimed the instruction, and a flag that reports a claimed encoding while the extension is switched off, so that the core can raise an illegal-instruction trap. The word forms work on the low half of source 1 and sign-extend their 32-bit result. They are decoded only when the datapath is wider than a word.

Top module: `sfo_unit`

## Requirements
- R1: Register left form (opcode 0110011, funct3 001, funct7 0010000): result = NOT((NOT src1) << src2[5:0]). The low vacated bits read as ones.
- R2: Register right form (opcode 0110011, funct3 101, funct7 0010000): result = NOT((NOT src1) >> src2[5:0]). The high vacated bits read as ones.
- R3: Immediate forms (opcode 0010011, funct3 001 left or 101 right) match only when instruction bits 31:27 are 00100. The shift amount is instruction bits 25:20, and bit 26 is ignored.
- R4: Word register forms (opcode 0111011, funct7 0010000, funct3 001 left or 101 right) shift src1[31:0] at 32-bit width with ones fill by src2[4:0]. The 32-bit result is sign-extended to 64 bits.
- R5: Word immediate forms (opcode 0011011, bits 31:25 = 0010000, funct3 001 left or 101 right) use instruction bits 24:20 as the shift amount, with the same 32-bit fill and sign extension as R4.
- R6: A shift amount of zero returns src1 unchanged in the 64-bit forms. In the word forms it returns src1[31:0] sign-extended.
- R7: When no encoding matches, valid and illegal are both low and the result is zero, whatever the enable is.
- R8: When an encoding matches and the extension enable is low, illegal is high, valid is low and the result is zero.
- R9: The register forms use only src2[5:0], and the word register forms use only src2[4:0]. The higher bits of src2 do not affect the result.
- R10: Valid and illegal are never high together, and valid implies that the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word under decode |
| src1 | input | 64 | First source operand (value shifted) |
| src2 | input | 64 | Second source operand (shift amount for register forms) |
| bm_en | input | 1 | Bit-manipulation extension enabled |
| result | output | 64 | Ones-fill shift result, zero unless valid |
| valid | output | 1 | Instruction claimed and executed by this slice |
| illegal | output | 1 | Instruction claimed but extension disabled |

## Verification
The slice holds no state, so any fault in decode or shifting shows at the ports in the same evaluation as the stimulus. A decode fault shows up as a wrong valid or illegal flag, or as a nonzero result on a foreign encoding. A fault in the shift amount selection shows up as a wrong count of filled ones, or as a dependence on src2 bits above the amount field. A fault in word handling shows up as upper bits that do not copy bit 31. Every shift amount of every form is compared against an independent bit-loop model over pseudo-random operands.

// File: rtl/sfo_pkg.sv
package sfo_pkg;

    localparam logic [6:0] OPC_REG     = 7'b0110011;
    localparam logic [6:0] OPC_IMM     = 7'b0010011;
    localparam logic [6:0] OPC_REG_W   = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W   = 7'b0011011;
    localparam logic [6:0] F7_ONES     = 7'b0010000;
    localparam logic [4:0] F5_ONES     = 5'b00100;
    localparam logic [2:0] F3_LEFT     = 3'b001;
    localparam logic [2:0] F3_RIGHT    = 3'b101;
    localparam int         AMT_W       = 6;

    typedef struct packed {
        logic             hit;
        logic             right;
        logic             word;
        logic [AMT_W-1:0] amt;
    } sfo_dec_t;

endpackage

// File: rtl/sfo_decode.sv
module sfo_decode
    import sfo_pkg::*;
#(
    parameter bit WORD_OK = 1'b1
) (
    input  logic [31:0]      instr,
    input  logic [AMT_W-1:0] rs2_amt,
    output sfo_dec_t         dec
);

    sfo_dec_t   dec_d;
    logic [6:0] opc_d;
    logic [2:0] f3_d;
    logic [6:0] f7_d;
    logic       f3_ok_d;

    always_comb begin
        opc_d   = instr[6:0];
        f3_d    = instr[14:12];
        f7_d    = instr[31:25];
        f3_ok_d = (f3_d == F3_LEFT) || (f3_d == F3_RIGHT);
        dec_d   = '0;
        if (f3_ok_d) begin
            if (opc_d == OPC_REG && f7_d == F7_ONES) begin
                dec_d.hit = 1'b1;
                dec_d.amt = rs2_amt;
            end else if (opc_d == OPC_IMM && instr[31:27] == F5_ONES) begin
                dec_d.hit = 1'b1;
                dec_d.amt = instr[25:20];
            end else if (WORD_OK && opc_d == OPC_REG_W && f7_d == F7_ONES) begin
                dec_d.hit  = 1'b1;
                dec_d.word = 1'b1;
                dec_d.amt  = {1'b0, rs2_amt[4:0]};
            end else if (WORD_OK && opc_d == OPC_IMM_W && f7_d == F7_ONES) begin
                dec_d.hit  = 1'b1;
                dec_d.word = 1'b1;
                dec_d.amt  = {1'b0, instr[24:20]};
            end
            dec_d.right = dec_d.hit && f3_d[2];
        end
    end

    assign dec = dec_d;

    logic unused_fields;
    assign unused_fields = ^{instr[19:15], instr[11:7]};

endmodule

// File: rtl/sfo_ones_shift.sv
module sfo_ones_shift #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [SW-1:0] amt,
    input  logic          right,
    output logic [W-1:0]  res
);

    logic [W-1:0] inv_d;
    logic [W-1:0] shf_d;

    always_comb begin
        inv_d = ~src;
        shf_d = right ? (inv_d >> amt) : (inv_d << amt);
        res   = ~shf_d;
    end

endmodule

// File: rtl/sfo_unit.sv
module sfo_unit
    import sfo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    localparam int SHW  = $clog2(XLEN),
    localparam int WSHW = $clog2(WLEN)
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    input  logic            bm_en,
    output logic [XLEN-1:0] result,
    output logic            valid,
    output logic            illegal
);

    sfo_dec_t        dec;
    logic [XLEN-1:0] full_res;
    logic [XLEN-1:0] word_ext;
    logic [XLEN-1:0] result_d;
    logic            valid_d;
    logic            illegal_d;

    sfo_decode #(.WORD_OK(XLEN > WLEN)) u_dec (
        .instr   (instr),
        .rs2_amt (src2[AMT_W-1:0]),
        .dec     (dec)
    );

    sfo_ones_shift #(.W(XLEN)) u_full (
        .src   (src1),
        .amt   (dec.amt[SHW-1:0]),
        .right (dec.right),
        .res   (full_res)
    );

    generate
        if (XLEN > WLEN) begin : g_word
            logic [WLEN-1:0] word_res;
            sfo_ones_shift #(.W(WLEN)) u_word (
                .src   (src1[WLEN-1:0]),
                .amt   (dec.amt[WSHW-1:0]),
                .right (dec.right),
                .res   (word_res)
            );
            assign word_ext = {{(XLEN-WLEN){word_res[WLEN-1]}}, word_res};

            // R4/R5: upper half copies bit 31 for word forms
            always_comb begin
                if (valid && dec.word)
                    a_r4_sign_ext: assert (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}});
            end
        end else begin : g_noword
            assign word_ext = '0;
        end
    endgenerate

    always_comb begin
        valid_d   = dec.hit && bm_en;
        illegal_d = dec.hit && !bm_en;
        result_d  = '0;
        if (valid_d)
            result_d = dec.word ? word_ext : full_res;
    end

    assign result  = result_d;
    assign valid   = valid_d;
    assign illegal = illegal_d;

    logic unused_src2;
    assign unused_src2 = ^src2[XLEN-1:AMT_W];

    always_comb begin
        // R7/R8: nothing leaks out unless claimed and enabled
        if (!valid)
            a_r7_quiet_zero: assert (result == '0);
        // R10: flags exclusive, valid needs the enable
        a_r10_flags_excl: assert (!(valid && illegal));
        if (valid)
            a_r10_valid_en: assert (bm_en);
        // R8: illegal only with the extension off
        if (illegal)
            a_r8_off_only: assert (!bm_en);
        // R6: zero shift passes source 1 through
        if (valid && !dec.word && dec.amt == '0)
            a_r6_zero_pass: assert (result == src1);
        // R1: low vacated bits are ones
        if (valid && !dec.word && !dec.right)
            a_r1_low_fill: assert (&(result | ({XLEN{1'b1}} << dec.amt[SHW-1:0])));
        // R2: high vacated bits are ones
        if (valid && !dec.word && dec.right)
            a_r2_high_fill: assert (&(result | ({XLEN{1'b1}} >> dec.amt[SHW-1:0])));
    end

endmodule

// File: tb/tb_sfo_unit.sv
module tb_sfo_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src1 = '0;
    logic [63:0] src2 = '0;
    logic        bm_en = 1'b0;
    logic [63:0] result;
    logic        valid;
    logic        illegal;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    sfo_unit dut (
        .instr(instr), .src1(src1), .src2(src2), .bm_en(bm_en),
        .result(result), .valid(valid), .illegal(illegal)
    );

    typedef struct packed {
        logic [2:0]  form;
        logic [5:0]  sh;
        logic [63:0] a;
        logic [63:0] b;
        logic        en;
        logic [63:0] exp;
        logic        v;
        logic        il;
    } vec_t;

    // forms: 0 reg-L 1 reg-R 2 imm-L 3 imm-R 4 wreg-L 5 wreg-R 6 wimm-L 7 wimm-R
    localparam vec_t VT [9] = '{
        '{3'd0, 6'd0,  64'h0, 64'h4,  1'b1, 64'h0000_0000_0000_000F, 1'b1, 1'b0}, // R1
        '{3'd1, 6'd0,  64'h0, 64'h8,  1'b1, 64'hFF00_0000_0000_0000, 1'b1, 1'b0}, // R2
        '{3'd0, 6'd0,  64'h1, 64'h40, 1'b1, 64'h0000_0000_0000_0001, 1'b1, 1'b0}, // R9
        '{3'd3, 6'd63, 64'h0, 64'h0,  1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0}, // R3
        '{3'd4, 6'd0,  64'hFFFF_FFFF_0000_0000, 64'h21, 1'b1, 64'h1, 1'b1, 1'b0}, // R4
        '{3'd5, 6'd0,  64'h0, 64'h4,  1'b1, 64'hFFFF_FFFF_F000_0000, 1'b1, 1'b0}, // R4
        '{3'd6, 6'd31, 64'h0, 64'h0,  1'b1, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0}, // R5
        '{3'd0, 6'd0,  64'h0, 64'h4,  1'b0, 64'h0,                   1'b0, 1'b1}, // R8
        '{3'd2, 6'd0,  64'h1234, 64'h0, 1'b1, 64'h1234,              1'b1, 1'b0}  // R6
    };

    function automatic logic [31:0] mk_instr(input int f, input logic [5:0] sh, input logic b26);
        logic [2:0] f3;
        f3 = f[0] ? 3'b101 : 3'b001;
        case (f)
            0, 1:    return {7'b0010000, 5'd3, 5'd2, f3, 5'd1, 7'b0110011};
            2, 3:    return {5'b00100, b26, sh, 5'd2, f3, 5'd1, 7'b0010011};
            4, 5:    return {7'b0010000, 5'd3, 5'd2, f3, 5'd1, 7'b0111011};
            default: return {7'b0010000, sh[4:0], 5'd2, f3, 5'd1, 7'b0011011};
        endcase
    endfunction

    function automatic logic [63:0] ref_ones(input int f, input logic [63:0] a,
                                             input logic [63:0] b, input logic [5:0] sh);
        logic [63:0] r;
        logic [31:0] w;
        int n;
        bit left;
        left = (f % 2) == 0;
        r = '0;
        if (f < 4) begin
            n = (f < 2) ? int'(b[5:0]) : int'(sh);
            for (int i = 0; i < 64; i++) begin
                if (left) r[i] = (i < n) ? 1'b1 : a[i-n];
                else      r[i] = (i >= 64 - n) ? 1'b1 : a[i+n];
            end
        end else begin
            n = (f < 6) ? int'(b[4:0]) : int'(sh[4:0]);
            for (int i = 0; i < 32; i++) begin
                if (left) w[i] = (i < n) ? 1'b1 : a[i-n];
                else      w[i] = (i >= 32 - n) ? 1'b1 : a[i+n];
            end
            for (int i = 0; i < 64; i++) r[i] = (i < 32) ? w[i] : w[31];
        end
        return r;
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic drive(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b, input logic e);
        @(posedge clk);
        instr = i; src1 = a; src2 = b; bm_en = e;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] er, input logic ev, input logic ei);
        n_chk++;
        if (result !== er || valid !== ev || illegal !== ei) begin
            n_bad++;
            $display("FAIL %s: result=%h exp=%h valid=%b exp=%b illegal=%b exp=%b",
                     tag, result, er, valid, ev, illegal, ei);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: result=%h exp=done valid=%b illegal=%b", result, valid, illegal);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset idle", 64'h0, 1'b0, 1'b0);

        for (int k = 0; k < 9; k++) begin
            drive(mk_instr(int'(VT[k].form), VT[k].sh, 1'b0), VT[k].a, VT[k].b, VT[k].en);
            check($sformatf("table[%0d] R1..R9", k), VT[k].exp, VT[k].v, VT[k].il);
        end

        // R7: foreign encodings
        drive(32'h0000_0013, 64'hFFFF, 64'h3, 1'b1);
        check("R7 addi", 64'h0, 1'b0, 1'b0);
        drive({7'b0100100, 5'd3, 5'd2, 3'b001, 5'd1, 7'b0110011}, 64'h5, 64'h1, 1'b1);
        check("R7 other funct7", 64'h0, 1'b0, 1'b0);
        drive({7'b0010000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011}, 64'h5, 64'h1, 1'b1);
        check("R7 other funct3", 64'h0, 1'b0, 1'b0);
        drive({5'b01001, 1'b0, 6'd4, 5'd2, 3'b001, 5'd1, 7'b0010011}, 64'h5, 64'h0, 1'b1);
        check("R3 imm top bits mismatch", 64'h0, 1'b0, 1'b0);
        drive({7'b0010001, 5'd4, 5'd2, 3'b001, 5'd1, 7'b0011011}, 64'h5, 64'h0, 1'b1);
        check("R5 word imm bit25 set", 64'h0, 1'b0, 1'b0);
        drive(32'h0000_0013, 64'hFFFF, 64'h3, 1'b0);
        check("R7 foreign with enable off", 64'h0, 1'b0, 1'b0);

        // R3: bit 26 ignored
        drive(mk_instr(3, 6'd4, 1'b1), 64'h0, 64'h0, 1'b1);
        check("R3 bit26 ignored", 64'hF000_0000_0000_0000, 1'b1, 1'b0);

        // R8: every form with the enable off
        for (int f = 0; f < 8; f++) begin
            drive(mk_instr(f, 6'd5, 1'b0), 64'h1234_5678_9ABC_DEF0, 64'h5, 1'b0);
            check($sformatf("R8 form %0d disabled", f), 64'h0, 1'b0, 1'b1);
        end

        // R6: zero shift in word form
        drive(mk_instr(5, 6'd0, 1'b0), 64'h1111_2222_8000_0001, 64'hFFFF_FFFF_FFFF_FFE0, 1'b1);
        check("R6 word zero shift", 64'hFFFF_FFFF_8000_0001, 1'b1, 1'b0);

        // R1..R5, R9: sweep of every amount with random operands
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 64; a++) begin
                logic [63:0] op1;
                logic [63:0] op2;
                logic [5:0]  sh;
                if (f >= 6 && a > 31) continue;
                lfsr = next_rand(lfsr); op1 = lfsr;
                lfsr = next_rand(lfsr);
                sh  = 6'(a);
                op2 = (f < 2) ? {lfsr[63:6], sh} : ((f < 6 && f >= 4) ? {lfsr[63:6], 1'b0, sh[4:0]} : lfsr);
                if (f >= 4 && f < 6) op2[5] = lfsr[0];
                drive(mk_instr(f, sh, lfsr[1]), op1, op2, 1'b1);
                check($sformatf("sweep form %0d amt %0d R1 R2 R3 R4 R5 R9", f, a),
                      ref_ones(f, op1, op2, sh), 1'b1, 1'b0);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule